// File: doc/BRIEF.md
# Receive Address Filter with Multicast Hash

This block decides whether a received Ethernet frame should be kept by looking only at its destination address. The six destination bytes arrive one per cycle on a byte stream. A strobe marks the first byte. While they arrive, the block compares them with a programmed station address and checks for the broadcast and group patterns. In the same cycles it runs a byte-wide CRC-32 over them. The upper six bits of that CRC select one bit of a 64-bit multicast hash table.

A small control word selects the accept policy: accept everything, accept any group address, accept broadcast, or accept group addresses whose hash bit is set. An address equal to the station address is always kept. The accept/reject decision appears on a registered output with a one-cycle valid strobe, in the cycle after the sixth address byte. Frame storage and FCS checking belong to the surrounding receive path.

Top module: `rx_addr_filter`

## Requirements
- R1: After a synchronous reset, `res_valid` and `res_accept` are 0. The control word, station address and hash table all read as zero, so an all-zero destination is accepted as a station match and group addresses are rejected.
- R2: `res_valid` is high for exactly one cycle, in the cycle after the clock edge that takes the sixth address byte. Idle cycles (`in_valid` low) between address bytes only delay it. `res_accept` is 0 whenever `res_valid` is 0.
- R3: With control bit 0 set, every address is accepted.
- R4: An address whose six bytes equal the station address is accepted whatever the control word holds. The first received byte is compared with `sta_wdata[7:0]`, and byte k with bits 8k+7..8k. A unicast address (first byte bit 0 clear) that differs in any byte is rejected unless control bit 0 is set.
- R5: The all-ones broadcast address is accepted when control bit 3 is set and rejected otherwise. Station match and control bit 0 are the exceptions. Broadcast is not subject to the multicast rules.
- R6: With control bit 1 set, every group address that is not broadcast is accepted. A group address is one whose first byte has bit 0 set.
- R7: With control bit 4 set, a non-broadcast group address is accepted when table bit h is set. Table bit h is `tbl_wdata[h]` of the last 64-bit block write, so byte h[5:3] and bit h[2:0]. h is defined from an LSB-first CRC-32 register R, reflected polynomial 0xEDB88320, preset to all ones with no final inversion, run over the six bytes in arrival order. Then h = {R[0],R[1],R[2],R[3],R[4],R[5]}.
- R8: A group address whose hash bit is clear is rejected when only control bit 4 is set. Control bits 2, 5, 6 and 7 have no effect on the decision.
- R9: A byte with `in_sof` high always starts a new address, even in the middle of one. Bytes after the sixth, or after reset, that carry no `in_sof` are ignored and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 8 | Control word (bit 0 all, bit 1 all group, bit 3 broadcast, bit 4 hash) |
| sta_we | input | 1 | Station address write enable |
| sta_wdata | input | 48 | Station address, first received byte in bits 7:0 |
| tbl_we | input | 1 | Hash table block write enable |
| tbl_wdata | input | 64 | Whole hash table, bit h is table bit h |
| in_valid | input | 1 | Address byte present |
| in_sof | input | 1 | This byte is the first destination byte |
| in_byte | input | 8 | Destination address byte |
| res_valid | output | 1 | Decision strobe |
| res_accept | output | 1 | Frame accepted (qualified by res_valid) |

## Verification
Directed addresses are sent under each control setting. A station-equal address, one differing only in its last byte and one differing in its first byte separate a full six-byte comparison from a partial one. Broadcast, plain group and unicast addresses are each tried under the broadcast-only, all-group and hash-only policies, so each address class is shown to be gated by the right bit. For hashing, several group addresses are used. Each is tried with a table holding only its own hash bit and again with every other bit set. This confirms both the CRC bit order and the byte/bit table index. Streams with idle gaps, mid-address restarts and surplus bytes check result timing against a per-cycle reference model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int CTL_W       = 8;
  localparam int CTL_PROMISC = 0;
  localparam int CTL_ALLGRP  = 1;
  localparam int CTL_BCAST   = 3;
  localparam int CTL_HASH    = 4;

  typedef struct packed {
    logic promisc;
    logic allgrp;
    logic bcast;
    logic hash;
  } rxf_ctl_t;

  // One byte through the reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc32_refl_byte(input logic [31:0] c_in,
                                                   input logic [7:0]  d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    return c;
  endfunction

endpackage

// File: rtl/dest_addr_track.sv
module dest_addr_track #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic [7:0]              in_byte,
  input  logic [8*ADDR_BYTES-1:0] sta_addr,
  output logic                    take,
  output logic                    first,
  output logic                    last,
  output logic                    is_group,
  output logic                    is_bcast,
  output logic                    sta_hit
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] POS_LAST = CW'(ADDR_BYTES - 1);
  localparam logic [CW-1:0] POS_DONE = CW'(ADDR_BYTES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pos;
  logic [CW-1:0] sel;
  logic          grp_q, ff_q, hit_q;
  logic          ff_cur, hit_cur;
  logic [7:0]    sta_byte;

  assign pos   = in_sof ? '0 : cnt_q;
  assign take  = in_valid && (in_sof || (cnt_q < POS_DONE));
  assign first = take && (pos == '0);
  assign last  = take && (pos == POS_LAST);
  assign sel   = (pos < POS_DONE) ? pos : '0;

  assign sta_byte = sta_addr[sel*8 +: 8];
  assign ff_cur   = ((pos == '0) ? 1'b1 : ff_q)  && (in_byte == 8'hFF);
  assign hit_cur  = ((pos == '0) ? 1'b1 : hit_q) && (in_byte == sta_byte);

  assign is_group = first ? in_byte[0] : grp_q;
  assign is_bcast = ff_cur;
  assign sta_hit  = hit_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= POS_DONE;
      grp_q <= 1'b0;
      ff_q  <= 1'b0;
      hit_q <= 1'b0;
    end else if (take) begin
      cnt_q <= pos + 1'b1;
      grp_q <= is_group;
      ff_q  <= ff_cur;
      hit_q <= hit_cur;
    end
  end

  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= POS_DONE);

  assert_single_last_R9: assert property (@(posedge clk) disable iff (rst)
    last |=> !last);

endmodule

// File: rtl/addr_hash_crc.sv
module addr_hash_crc #(
  parameter int HASH_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              start,
  input  logic [7:0]        din,
  output logic [HASH_W-1:0] idx
);
  import rxf_pkg::*;

  logic [31:0] crc_q;
  logic [31:0] crc_base;
  logic [31:0] crc_next;

  assign crc_base = start ? 32'hFFFF_FFFF : crc_q;
  assign crc_next = crc32_refl_byte(crc_base, din);

  // Index is the top of the MSB-first CRC, i.e. the low bits reversed.
  for (genvar i = 0; i < HASH_W; i++) begin : g_idx
    assign idx[i] = crc_next[HASH_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= 32'hFFFF_FFFF;
    else if (step) crc_q <= crc_next;
  end

endmodule

// File: rtl/mcast_hash_table.sv
module mcast_hash_table #(
  parameter int HASH_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [2**HASH_W-1:0] wdata,
  input  logic [HASH_W-1:0]    rd_idx,
  output logic                 rd_bit
);
  localparam int NBYTES = 2**(HASH_W-3);

  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    for (int k = 0; k < NBYTES; k++) begin
      if (rst)     mem[k] <= '0;
      else if (we) mem[k] <= wdata[8*k +: 8];
    end
  end

  assign rd_bit = mem[rd_idx[HASH_W-1:3]][rd_idx[2:0]];

  for (genvar k = 0; k < NBYTES; k++) begin : g_chk
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(mem[k]));
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctl_we,
  input  logic [7:0]              ctl_wdata,
  input  logic                    sta_we,
  input  logic [8*ADDR_BYTES-1:0] sta_wdata,
  input  logic                    tbl_we,
  input  logic [2**HASH_W-1:0]    tbl_wdata,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic [7:0]              in_byte,
  output logic                    res_valid,
  output logic                    res_accept
);
  import rxf_pkg::*;

  rxf_ctl_t                ctl_q;
  logic [8*ADDR_BYTES-1:0] sta_q;
  logic                    trk_take, trk_first, trk_last;
  logic                    trk_group, trk_bcast, trk_hit;
  logic [HASH_W-1:0]       hash_idx;
  logic                    hash_bit;
  logic                    accept_now;
  logic                    unused_ctl;

  assign unused_ctl = ^{ctl_wdata[7:5], ctl_wdata[2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      sta_q <= '0;
    end else begin
      if (ctl_we) begin
        ctl_q.promisc <= ctl_wdata[CTL_PROMISC];
        ctl_q.allgrp  <= ctl_wdata[CTL_ALLGRP];
        ctl_q.bcast   <= ctl_wdata[CTL_BCAST];
        ctl_q.hash    <= ctl_wdata[CTL_HASH];
      end
      if (sta_we) sta_q <= sta_wdata;
    end
  end

  dest_addr_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sof(in_sof), .in_byte(in_byte),
    .sta_addr(sta_q),
    .take(trk_take), .first(trk_first), .last(trk_last),
    .is_group(trk_group), .is_bcast(trk_bcast), .sta_hit(trk_hit)
  );

  addr_hash_crc #(.HASH_W(HASH_W)) u_crc (
    .clk(clk), .rst(rst),
    .step(trk_take), .start(trk_first), .din(in_byte),
    .idx(hash_idx)
  );

  mcast_hash_table #(.HASH_W(HASH_W)) u_tbl (
    .clk(clk), .rst(rst),
    .we(tbl_we), .wdata(tbl_wdata),
    .rd_idx(hash_idx), .rd_bit(hash_bit)
  );

  always_comb begin
    if (ctl_q.promisc || trk_hit)
      accept_now = 1'b1;
    else if (trk_bcast)
      accept_now = ctl_q.bcast;
    else
      accept_now = trk_group && (ctl_q.allgrp || (ctl_q.hash && hash_bit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
    end else begin
      res_valid  <= trk_last;
      res_accept <= trk_last && accept_now;
    end
  end

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_accept_qual_R2: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_accept);

  assert_promisc_R3: assert property (@(posedge clk) disable iff (rst)
    (trk_last && ctl_q.promisc) |=> (res_valid && res_accept));

  assert_station_R4: assert property (@(posedge clk) disable iff (rst)
    (trk_last && trk_hit) |=> res_accept);

endmodule

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        sta_we = 1'b0;
  logic [47:0] sta_wdata = '0;
  logic        tbl_we = 1'b0;
  logic [63:0] tbl_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        res_valid, res_accept;

  always #2 clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sta_we(sta_we), .sta_wdata(sta_wdata),
    .tbl_we(tbl_we), .tbl_wdata(tbl_wdata),
    .in_valid(in_valid), .in_sof(in_sof), .in_byte(in_byte),
    .res_valid(res_valid), .res_accept(res_accept)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    started  = 0;
  bit    finished = 0;

  // Reference model state
  logic [7:0]  m_ctl;
  logic [47:0] m_sta;
  logic [63:0] m_tbl;
  logic [7:0]  m_buf [6];
  int          m_cnt;
  logic        exp_v, exp_a;

  function automatic int hash_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic        fb;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++) begin
        fb = c[31] ^ a[8*k+b];
        c  = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return int'(c[31:26]);
  endfunction

  function automatic logic decide(input logic [47:0] a);
    logic bc  = (a == 48'hFFFF_FFFF_FFFF);
    logic grp = a[0];
    if (m_ctl[0] || a == m_sta) return 1'b1;
    if (bc) return m_ctl[3];
    if (!grp) return 1'b0;
    return m_ctl[1] || (m_ctl[4] && m_tbl[hash_of(a)]);
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_ctl = '0; m_sta = '0; m_tbl = '0; m_cnt = 6;
      exp_v = 0; exp_a = 0;
    end else begin
      logic [47:0] a;
      exp_v = 0; exp_a = 0;
      if (in_valid && (in_sof || m_cnt < 6)) begin
        if (in_sof) m_cnt = 0;
        m_buf[m_cnt] = in_byte;
        m_cnt++;
        if (m_cnt == 6) begin
          for (int k = 0; k < 6; k++) a[8*k +: 8] = m_buf[k];
          exp_v = 1;
          exp_a = decide(a);
        end
      end
      if (ctl_we) m_ctl = ctl_wdata;
      if (sta_we) m_sta = sta_wdata;
      if (tbl_we) m_tbl = tbl_wdata;
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      n_checks++;
      if (res_valid !== exp_v || res_accept !== exp_a) begin
        n_fail++;
        $display("FAIL %s: valid/accept got %b/%b expected %b/%b at %0t",
                 cur_req, res_valid, res_accept, exp_v, exp_a, $time);
      end
    end
  end

  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic send_addr(input logic [47:0] a, input int gap);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (k == 0); in_byte = a[8*k +: 8];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 0; in_sof = 0;
      end
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic raw_byte(input logic [7:0] b, input logic sof);
    @(negedge clk);
    in_valid = 1; in_sof = sof; in_byte = b;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_sta(input logic [47:0] v);
    @(negedge clk); sta_we = 1; sta_wdata = v;
    @(negedge clk); sta_we = 0;
  endtask

  task automatic wr_tbl(input logic [63:0] v);
    @(negedge clk); tbl_we = 1; tbl_wdata = v;
    @(negedge clk); tbl_we = 0;
  endtask

  logic [47:0] grp_a [4];

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    n_checks++;
    if (res_valid !== 0 || res_accept !== 0) begin
      n_fail++;
      $display("FAIL R1: reset outputs %b/%b expected 0/0", res_valid, res_accept);
    end
    rst = 0;
    send_addr(48'h0, 0);
    wr_ctl(8'h10);
    send_addr(mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01), 0);

    cur_req = "R9";
    raw_byte(8'hAA, 0); raw_byte(8'hBB, 0);
    @(negedge clk); in_valid = 0;
    repeat (3) @(negedge clk);

    cur_req = "R4";
    wr_ctl(8'h00);
    wr_sta(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55));
    send_addr(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 0);
    send_addr(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56), 0);
    send_addr(mk(8'h06, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 0);
    wr_ctl(8'hFE);
    send_addr(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1);

    cur_req = "R5";
    wr_ctl(8'h00);
    send_addr(48'hFFFF_FFFF_FFFF, 0);
    wr_ctl(8'h08);
    send_addr(48'hFFFF_FFFF_FFFF, 0);
    send_addr(mk(8'h01, 8'h00, 8'h5E, 8'h7F, 8'h00, 8'h02), 0);

    cur_req = "R6";
    wr_ctl(8'h02);
    send_addr(mk(8'h01, 8'h00, 8'h5E, 8'h7F, 8'h00, 8'h02), 0);
    send_addr(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01), 0);
    send_addr(48'hFFFF_FFFF_FFFF, 0);
    send_addr(mk(8'h00, 8'h1B, 8'h21, 8'h3C, 8'h4D, 8'h5E), 0);

    cur_req = "R3";
    wr_ctl(8'h01);
    send_addr(mk(8'h00, 8'h1B, 8'h21, 8'h3C, 8'h4D, 8'h5E), 0);
    send_addr(48'hFFFF_FFFF_FFFF, 0);
    send_addr(mk(8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h0E), 0);

    grp_a[0] = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'hFB);
    grp_a[1] = mk(8'h33, 8'h33, 8'hFF, 8'h12, 8'h34, 8'h56);
    grp_a[2] = mk(8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h00);
    grp_a[3] = mk(8'hAB, 8'hCD, 8'hEF, 8'h01, 8'h23, 8'h45);
    wr_ctl(8'h10);
    for (int i = 0; i < 4; i++) begin
      cur_req = "R7";
      wr_tbl(64'd1 << hash_of(grp_a[i]));
      send_addr(grp_a[i], i % 2);
      cur_req = "R8";
      wr_tbl(~(64'd1 << hash_of(grp_a[i])));
      send_addr(grp_a[i], 0);
    end
    cur_req = "R8";
    wr_tbl(64'h0);
    wr_ctl(8'hF4);
    send_addr(grp_a[0], 0);
    send_addr(mk(8'h00, 8'h1B, 8'h21, 8'h3C, 8'h4D, 8'h5E), 0);

    cur_req = "R2";
    wr_ctl(8'h08);
    send_addr(48'hFFFF_FFFF_FFFF, 3);
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 6; k++) raw_byte(8'hFF, k == 0);
    end
    @(negedge clk); in_valid = 0;
    repeat (3) @(negedge clk);

    cur_req = "R9";
    raw_byte(8'hFF, 1); raw_byte(8'hFF, 0); raw_byte(8'hFF, 0);
    for (int k = 0; k < 6; k++) raw_byte(8'h00 + 8'(k), k == 0);
    for (int k = 0; k < 4; k++) raw_byte(8'hFF, 0);
    @(negedge clk); in_valid = 0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule